// File: doc/BRIEF.md
# Parallel Four-Channel DAC Code Loader

This block is the digital front end of a four-channel, 14-bit converter that a host writes over a parallel bus. Each write names a channel through a small address field and carries a data word. The data goes into that channel's input register, and the converter does not see it yet. A separate load strobe moves the input registers into the output latches, which drive the converter codes. A host on a 14-bit bus loads a whole code in one write. A host on an 8-bit bus sets the bus-width strap and sends each code as two writes. The byte-select input steers the first write to the low eight bits and the second to the upper six.

One address bit turns a write into a broadcast, so that all four input registers take the same field on the same edge. An active-low clear input forces every output to a fixed clear code. The outputs stay there after clear is released, and they return to the latched codes only when the load strobe is next applied. All inputs are sampled on the system clock. A write takes effect on the clock edge at which the sampled write strobe is seen rising while chip select is low.

Top module: `dacld_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every channel output is 0, every input register is 0 and `clr_hold` is 0.
- R2: A write happens on a clock edge where `wr_n` is sampled high, was sampled low on the previous edge, and `cs_n` is sampled low. A rising `wr_n` while `cs_n` is high changes no register.
- R3: With `addr[2]` = 0, `addr[1:0]` picks channel 0 to 3 (value k selects channel k, output bits `dac_out[14k+13:14k]`). Only that channel's input register changes.
- R4: With `byte_bus` = 0, a write loads all of `data[13:0]` into the selected input register and `byshf` has no effect.
- R5: With `byte_bus` = 1 and `byshf` = 1, a write loads `data[7:0]` into bits 7:0 of the input register. Bits 13:8 keep their value.
- R6: With `byte_bus` = 1 and `byshf` = 0, a write loads `data[5:0]` into bits 13:8, with `data[5]` going to bit 13. Bits 7:0 keep their value, and `data[13:6]` is ignored.
- R7: With `addr[2]` = 1, one write updates all four input registers on the same edge, using the field rules of R4 to R6.
- R8: On each edge where `ldac_n` is sampled low, every output latch copies its input register. If a write lands on the same edge, the latch takes the contents from before that write. With `ldac_n` high, outputs do not change unless clear acts.
- R9: An edge with `clr_n` sampled low sets `clr_hold`, and every output then shows the clear code 14'h2000. The hold persists after `clr_n` rises. It ends on the first edge with `clr_n` high and `ldac_n` low, and after that edge the outputs show the freshly loaded latches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe, acted on at its rising edge |
| addr | input | 3 | Bit 2 broadcast, bits 1:0 channel number |
| data | input | 14 | Parallel data bus |
| byshf | input | 1 | Byte select in byte-bus mode: 1 low byte, 0 upper six bits |
| byte_bus | input | 1 | Strap: 1 selects two-write byte mode, 0 full-width writes |
| ldac_n | input | 1 | Active-low load strobe, input registers to output latches |
| clr_n | input | 1 | Active-low clear |
| dac_out | output | 56 | Four 14-bit converter codes, channel k at bits 14k+13:14k |
| clr_hold | output | 1 | High while outputs are held at the clear code |

## Verification
Two collisions matter. A write can arrive on the same edge at which a held-low load strobe copies the registers, and a clear can coincide with the load strobe that would otherwise end a hold. The bench keeps `ldac_n` low while it completes a write. It also pulls `clr_n` and `ldac_n` low together, then lets go of `clr_n` while the strobe is still low. A behavioural model compares all outputs every cycle. For the first collision the model expects the pre-write code for one cycle and the new code after that. For the second it expects the clear code for as long as `clr_n` is low, and the latched codes only after an edge where the strobe is low and `clr_n` is high.

// File: rtl/dacld_pkg.sv
`timescale 1ns/1ps
package dacld_pkg;
  parameter int DAC_W = 14;
  parameter int LO_W  = 8;
  parameter int HI_W  = DAC_W - LO_W;

  typedef logic [DAC_W-1:0] code_t;

  // Field merge for one write: full word, low byte, or upper bits from the low lines.
  function automatic code_t fn_merge(input code_t old_v, input code_t din,
                                     input logic byte_bus, input logic byshf);
    code_t res;
    if (!byte_bus) begin
      res = din;
    end else if (byshf) begin
      res = {old_v[DAC_W-1:LO_W], din[LO_W-1:0]};
    end else begin
      res = {din[HI_W-1:0], old_v[LO_W-1:0]};
    end
    return res;
  endfunction

  // Output select: clear level while held, latch otherwise.
  function automatic code_t fn_view(input code_t latch_v, input code_t clr_v,
                                    input logic hold);
    return hold ? clr_v : latch_v;
  endfunction
endpackage

// File: rtl/dacld_wr_decode.sv
`timescale 1ns/1ps
module dacld_wr_decode #(
  parameter int NCH   = 4,
  parameter int CH_AW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic [CH_AW:0]   addr,
  output logic             wr_fire,
  output logic [NCH-1:0]   ch_en
);
  logic wr_n_q;
  logic wr_rise;
  logic bcast;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_n_q <= 1'b1;
    end else begin
      wr_n_q <= wr_n;
    end
  end

  assign wr_rise = !wr_n_q && wr_n;
  assign wr_fire = wr_rise && !cs_n;
  assign bcast   = addr[CH_AW];

  for (genvar k = 0; k < NCH; k++) begin : g_sel
    assign ch_en[k] = wr_fire && (bcast || (addr[CH_AW-1:0] == CH_AW'(k)));
  end
endmodule

// File: rtl/dacld_clear_ctl.sv
`timescale 1ns/1ps
module dacld_clear_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n,
  input  logic ldac_n,
  output logic hold
);
  logic hold_q;
  logic hold_set;
  logic hold_rel;

  assign hold_set = !clr_n;
  assign hold_rel = clr_n && !ldac_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else if (hold_set) begin
      hold_q <= 1'b1;
    end else if (hold_rel) begin
      hold_q <= 1'b0;
    end
  end

  assign hold = hold_q;
endmodule

// File: rtl/dacld_chan.sv
`timescale 1ns/1ps
module dacld_chan
  import dacld_pkg::*;
#(
  parameter logic [DAC_W-1:0] CLR_CODE = 14'h2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DAC_W-1:0] din,
  input  logic             byte_bus,
  input  logic             byshf,
  input  logic             load,
  input  logic             hold,
  output logic [DAC_W-1:0] in_reg,
  output logic [DAC_W-1:0] code_out
);
  code_t in_q;
  code_t lat_q;
  code_t in_nxt;

  assign in_nxt = fn_merge(in_q, din, byte_bus, byshf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q <= '0;
    end else if (wr_en) begin
      in_q <= in_nxt;
    end
  end

  // Latch takes the pre-write register value when both land on one edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (load) begin
      lat_q <= in_q;
    end
  end

  assign in_reg   = in_q;
  assign code_out = fn_view(lat_q, CLR_CODE, hold);
endmodule

// File: rtl/dacld_top.sv
`timescale 1ns/1ps
module dacld_top
  import dacld_pkg::*;
#(
  parameter int                NCH      = 4,
  parameter logic [DAC_W-1:0]  CLR_CODE = 14'h2000,
  localparam int               CH_AW    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int               OUT_W    = NCH * DAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic [CH_AW:0]   addr,
  input  logic [DAC_W-1:0] data,
  input  logic             byshf,
  input  logic             byte_bus,
  input  logic             ldac_n,
  input  logic             clr_n,
  output logic [OUT_W-1:0] dac_out,
  output logic             clr_hold
);
  logic             wr_fire;
  logic [NCH-1:0]   ch_en;
  logic [OUT_W-1:0] inreg_flat;
  logic             load_all;

  assign load_all = !ldac_n;

  dacld_wr_decode #(.NCH(NCH), .CH_AW(CH_AW)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .wr_n   (wr_n),
    .addr   (addr),
    .wr_fire(wr_fire),
    .ch_en  (ch_en)
  );

  dacld_clear_ctl u_clr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_n (clr_n),
    .ldac_n(ldac_n),
    .hold  (clr_hold)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    dacld_chan #(.CLR_CODE(CLR_CODE)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ch_en[k]),
      .din     (data),
      .byte_bus(byte_bus),
      .byshf   (byshf),
      .load    (load_all),
      .hold    (clr_hold),
      .in_reg  (inreg_flat[k*DAC_W +: DAC_W]),
      .code_out(dac_out[k*DAC_W +: DAC_W])
    );
  end
endmodule

// File: rtl/dacld_chk.sv
`timescale 1ns/1ps
module dacld_chk #(
  parameter int          NCH   = 4,
  parameter int          DW    = 14,
  parameter int          AW    = 2,
  parameter logic [13:0] CLR_V = 14'h2000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW:0]       addr,
  input logic              ldac_n,
  input logic              clr_n,
  input logic [NCH*DW-1:0] dac_out,
  input logic              clr_hold,
  input logic              wr_fire,
  input logic [NCH-1:0]    ch_en,
  input logic [NCH*DW-1:0] inreg_flat
);
  assert_no_write_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(inreg_flat));

  assert_one_channel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !addr[AW]) |-> ($countones(ch_en) == 1));

  assert_idle_no_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |-> (ch_en == '0));

  assert_bcast_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && addr[AW]) |-> (&ch_en));

  assert_out_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ldac_n && clr_n) |=> $stable(dac_out));

  assert_clear_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> clr_hold);

  assert_clear_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hold |-> (dac_out == {NCH{CLR_V}}));

  assert_hold_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hold && ldac_n) |=> clr_hold);
endmodule

bind dacld_top dacld_chk #(
  .NCH  (NCH),
  .DW   (dacld_pkg::DAC_W),
  .AW   (CH_AW),
  .CLR_V(CLR_CODE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .ldac_n    (ldac_n),
  .clr_n     (clr_n),
  .dac_out   (dac_out),
  .clr_hold  (clr_hold),
  .wr_fire   (wr_fire),
  .ch_en     (ch_en),
  .inreg_flat(inreg_flat)
);

// File: tb/dacld_top_tb.sv
`timescale 1ns/1ps
module dacld_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [2:0]  addr = '0;
  logic [13:0] data = '0;
  logic        byshf = 1'b1;
  logic        byte_bus = 1'b0;
  logic        ldac_n = 1'b1;
  logic        clr_n = 1'b1;
  logic [55:0] dac_out;
  logic        clr_hold;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 0;

  // reference model state
  int m_in [4];
  int m_lat[4];
  bit m_hold = 0;
  bit m_wr_prev = 1;

  always #2.5 clk = ~clk;

  dacld_top u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
    .data(data), .byshf(byshf), .byte_bus(byte_bus), .ldac_n(ldac_n),
    .clr_n(clr_n), .dac_out(dac_out), .clr_hold(clr_hold)
  );

  function automatic int new_field(int old_v, int d, bit bb, bit bs);
    if (!bb) return d & 16'h3FFF;
    if (bs)  return (old_v & 16'h3F00) | (d & 16'h00FF);
    return ((d & 16'h003F) * 256) | (old_v & 16'h00FF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin m_in[k] = 0; m_lat[k] = 0; end
      m_hold = 0; m_wr_prev = 1;
    end else begin
      if (!ldac_n) for (int k = 0; k < 4; k++) m_lat[k] = m_in[k];
      if (!clr_n) m_hold = 1;
      else if (!ldac_n) m_hold = 0;
      if (m_wr_prev == 0 && wr_n == 1 && cs_n == 0) begin
        for (int k = 0; k < 4; k++)
          if (addr[2] || addr[1:0] == k[1:0])
            m_in[k] = new_field(m_in[k], data, byte_bus, byshf);
      end
      m_wr_prev = wr_n;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int k = 0; k < 4; k++) begin
        int exp_v;
        exp_v = m_hold ? 16'h2000 : m_lat[k];
        checks++;
        if (dac_out[k*14 +: 14] !== exp_v[13:0]) begin
          errors++;
          $display("FAIL %s model ch%0d actual %h expected %h", cur_req, k,
                   dac_out[k*14 +: 14], exp_v[13:0]);
        end
      end
      checks++;
      if (clr_hold !== m_hold) begin
        errors++;
        $display("FAIL %s model clr_hold actual %b expected %b", cur_req, clr_hold, m_hold);
      end
    end
  end

  task automatic expect_ch(int k, logic [13:0] v, string tag);
    checks++;
    if (dac_out[k*14 +: 14] !== v) begin
      errors++;
      $display("FAIL %s ch%0d actual %h expected %h", tag, k, dac_out[k*14 +: 14], v);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [13:0] d, logic bs, logic cs);
    @(negedge clk); cs_n = cs; wr_n = 0; addr = a; data = d; byshf = bs;
    @(negedge clk); wr_n = 1;
    @(negedge clk); cs_n = 1;
  endtask

  task automatic pulse_ld();
    @(negedge clk); ldac_n = 0;
    @(negedge clk); ldac_n = 1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired during %s", cur_req);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    for (int k = 0; k < 4; k++) expect_ch(k, 14'h0000, "R1");
    checks++;
    if (clr_hold !== 1'b0) begin errors++; $display("FAIL R1 clr_hold actual %b expected 0", clr_hold); end

    // R4 full-width, byshf ignored; R8 not visible before load
    cur_req = "R4";
    wr(3'b010, 14'h1ABC, 1'b0, 1'b0);
    @(negedge clk);
    expect_ch(2, 14'h0000, "R8");
    pulse_ld();
    expect_ch(2, 14'h1ABC, "R4");
    expect_ch(0, 14'h0000, "R3");
    expect_ch(1, 14'h0000, "R3");
    expect_ch(3, 14'h0000, "R3");

    // R2 chip select high blocks the write
    cur_req = "R2";
    wr(3'b000, 14'h0555, 1'b1, 1'b1);
    pulse_ld();
    expect_ch(0, 14'h0000, "R2");

    // R5/R6 byte mode two-write load on channel 1
    cur_req = "R5";
    byte_bus = 1;
    wr(3'b001, 14'h00A5, 1'b1, 1'b0);
    cur_req = "R6";
    wr(3'b001, 14'h002D, 1'b0, 1'b0);
    pulse_ld();
    expect_ch(1, 14'h2DA5, "R6");
    cur_req = "R5";
    wr(3'b001, 14'h003C, 1'b1, 1'b0);
    pulse_ld();
    expect_ch(1, 14'h2D3C, "R5");
    cur_req = "R6";
    wr(3'b001, 14'h3FC1, 1'b0, 1'b0);
    pulse_ld();
    expect_ch(1, 14'h013C, "R6");
    expect_ch(2, 14'h1ABC, "R3");

    // R7 broadcast in both modes
    cur_req = "R7";
    byte_bus = 0;
    wr(3'b101, 14'h0777, 1'b1, 1'b0);
    pulse_ld();
    for (int k = 0; k < 4; k++) expect_ch(k, 14'h0777, "R7");
    byte_bus = 1;
    wr(3'b110, 14'h3F11, 1'b1, 1'b0);
    pulse_ld();
    for (int k = 0; k < 4; k++) expect_ch(k, 14'h0711, "R7");
    byte_bus = 0;

    // R8 write and load on the same edge
    cur_req = "R8";
    @(negedge clk); ldac_n = 0;
    @(negedge clk); cs_n = 0; wr_n = 0; addr = 3'b011; data = 14'h1234;
    @(negedge clk); wr_n = 1;
    @(negedge clk); cs_n = 1;
    expect_ch(3, 14'h0711, "R8");
    @(negedge clk);
    expect_ch(3, 14'h1234, "R8");
    ldac_n = 1;

    // R9 clear, hold after release, clear with load together
    cur_req = "R9";
    @(negedge clk); clr_n = 0;
    @(negedge clk); clr_n = 1;
    for (int k = 0; k < 4; k++) expect_ch(k, 14'h2000, "R9");
    wr(3'b000, 14'h0ABC, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    expect_ch(0, 14'h2000, "R9");
    checks++;
    if (clr_hold !== 1'b1) begin errors++; $display("FAIL R9 clr_hold actual %b expected 1", clr_hold); end
    clr_n = 0; ldac_n = 0;
    @(negedge clk);
    expect_ch(0, 14'h2000, "R9");
    clr_n = 1;
    @(negedge clk);
    ldac_n = 1;
    expect_ch(0, 14'h0ABC, "R9");
    expect_ch(3, 14'h1234, "R9");
    checks++;
    if (clr_hold !== 1'b0) begin errors++; $display("FAIL R9 clr_hold actual %b expected 0", clr_hold); end

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule